// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block multiplies an A_W-bit multiplicand by a B_W-bit multiplier and accumulates the products into a register. The register is wider than the product by GUARD extra bits. Each new product is either added to or subtracted from the running sum. A load control restarts the sum from the current product. A sticky overflow flag reports when the sum wraps.

Input, control, pipeline and output registers can each be kept or removed by a parameter. This trades latency against clock rate. Operands can come from the direct data pins or from chain inputs. The operands after the input stage are driven out on chain outputs, so that a neighbouring unit can take them.

Every register shares one clock, one clock enable (`ce`) and one synchronous reset. The data path has no valid/ready handshake. The stream advances one step on each clock edge where `ce` is high. Holding `ce` low is the only way to stall it, and a stall loses no data.

Top module: `mac_unit`

## Requirements
- R1: In unsigned mode (`is_signed`=0), both operands are zero-extended. The unit accumulates their A_W+B_W-bit product into an accumulator of A_W+B_W+GUARD bits.
- R2: In signed mode (`is_signed`=1), both operands are two's complement. The product is sign-extended before it is accumulated.
- R3: With `sub`=1 the product is subtracted from the sum. With `sub`=0 it is added. This choice is made for each product.
- R4: With `load`=1 the accumulator takes the extended product, or its negation when `sub`=1. The previous sum is ignored and the overflow flag is cleared.
- R5: In signed mode, overflow is detected when an add of two values of equal sign gives a result of the other sign. It is also detected when a subtract of values of different sign gives a result whose sign differs from the previous sum.
- R6: In unsigned mode, overflow is detected on a carry out of the top accumulator bit when adding, or on a borrow when subtracting.
- R7: Once set, `ovf_out` stays high until the next load or reset.
- R8: The first change at `acc_out` comes a fixed number of clock edges after a change at the operands. That number is (IN_A_REG or IN_B_REG) + PIPE_REG + 1 + OUT_REG. This holds for all 16 register combinations.
- R9: With `use_chain`=1 the operands come from `chain_a_in` and `chain_b_in`. `chain_a_out` and `chain_b_out` show the operands after the input stage.
- R10: While `ce` is low, no register changes. The result stays put, and the inputs applied during that time have no effect.
- R11: With `rst` high at a clock edge, every register clears at that edge. `acc_out` becomes 0 and `ovf_out` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes all registers |
| a_in | input | A_W | Direct multiplicand |
| b_in | input | B_W | Direct multiplier |
| chain_a_in | input | A_W | Multiplicand from neighbouring unit |
| chain_b_in | input | B_W | Multiplier from neighbouring unit |
| use_chain | input | 1 | 1 selects the chain operand inputs |
| is_signed | input | 1 | 1 selects two's-complement operands |
| sub | input | 1 | 1 subtracts the product |
| load | input | 1 | 1 reseeds the accumulator from the product |
| chain_a_out | output | A_W | Multiplicand after the input stage |
| chain_b_out | output | B_W | Multiplier after the input stage |
| acc_out | output | A_W+B_W+GUARD | Accumulated result |
| ovf_out | output | 1 | Sticky overflow flag |

## Verification
Most corrupted internal state appears at `acc_out` a fixed number of edges later, equal to the latency of R8. An unexpected value means a stage was dropped or a register was added. A sum that has drifted stays wrong until the next load, so a flush of added zeros followed by a single compare exposes it. A wrong overflow state shows on `ovf_out` with the same delay and stays there because the flag is sticky. Skew between operand and control stages shows up as a load or subtract applied to the wrong product.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic is_signed;
    logic sub;
    logic load;
  } mac_ctrl_t;

  localparam int CTRL_W = $bits(mac_ctrl_t);
endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)     r <= '0;
        else if (ce) r <= d;
      end
      assign q = r;

      // R10: a stalled stage keeps its contents
      a_r10_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int A_W  = 8,
  parameter int B_W  = 8,
  parameter bit PIPE = 1'b1,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  mac_ctrl_t      ctrl_in,
  output logic [P_W-1:0] prod,
  output mac_ctrl_t      ctrl_out
);
  logic signed [A_W:0]     ax;
  logic signed [B_W:0]     bx;
  logic signed [P_W+1:0]   full;
  logic [P_W+CTRL_W-1:0]   st_d, st_q;

  always_comb begin
    ax   = {ctrl_in.is_signed & a[A_W-1], a};
    bx   = {ctrl_in.is_signed & b[B_W-1], b};
    full = ax * bx;
  end

  assign st_d = {full[P_W-1:0], ctrl_in};

  mac_stage #(.W(P_W + CTRL_W), .EN(PIPE)) u_pipe (
    .clk(clk), .rst(rst), .ce(ce), .d(st_d), .q(st_q)
  );

  assign prod     = st_q[P_W+CTRL_W-1:CTRL_W];
  assign ctrl_out = mac_ctrl_t'(st_q[CTRL_W-1:0]);
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int P_W   = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [P_W-1:0]   prod,
  input  mac_ctrl_t        ctrl,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf_q
);
  localparam int EXT_W = ACC_W - P_W;

  logic [ACC_W-1:0] ext, base, acc_n;
  logic [ACC_W:0]   sum_w;
  logic             ovf_now, ovf_d;
  logic             s_base, s_ext, s_res;

  always_comb begin
    ext    = {{EXT_W{ctrl.is_signed & prod[P_W-1]}}, prod};
    base   = ctrl.load ? '0 : acc_q;
    sum_w  = ctrl.sub ? ({1'b0, base} - {1'b0, ext}) : ({1'b0, base} + {1'b0, ext});
    acc_n  = sum_w[ACC_W-1:0];
    s_base = base[ACC_W-1];
    s_ext  = ext[ACC_W-1];
    s_res  = acc_n[ACC_W-1];
    if (ctrl.load)
      ovf_now = 1'b0;
    else if (ctrl.is_signed)
      ovf_now = ctrl.sub ? ((s_base != s_ext) && (s_res != s_base))
                         : ((s_base == s_ext) && (s_res != s_base));
    else
      ovf_now = sum_w[ACC_W];
    ovf_d = ctrl.load ? 1'b0 : (ovf_q | ovf_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ce) begin
      acc_q <= acc_n;
      ovf_q <= ovf_d;
    end
  end

  // R7: flag persists without a load
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ce && !ctrl.load && ovf_q) |=> ovf_q);
  // R4: load clears the flag
  a_r4_load_clears: assert property (@(posedge clk) disable iff (rst)
    (ce && ctrl.load) |=> !ovf_q);
  // R10: stall freezes accumulator and flag
  a_r10_acc_freeze: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(acc_q) && $stable(ovf_q)));
  // R11: synchronous clear
  a_r11_acc_reset: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !ovf_q));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter int GUARD    = 16,
  parameter bit IN_A_REG = 1'b1,
  parameter bit IN_B_REG = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  localparam int P_W     = A_W + B_W,
  localparam int ACC_W   = P_W + GUARD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic [A_W-1:0]   chain_a_in,
  input  logic [B_W-1:0]   chain_b_in,
  input  logic             use_chain,
  input  logic             is_signed,
  input  logic             sub,
  input  logic             load,
  output logic [A_W-1:0]   chain_a_out,
  output logic [B_W-1:0]   chain_b_out,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_out
);
  localparam bit CTRL_REG = IN_A_REG | IN_B_REG;

  logic [A_W-1:0]    a_sel, a_q;
  logic [B_W-1:0]    b_sel, b_q;
  mac_ctrl_t         ctrl_d, ctrl_q, ctrl_m;
  logic [CTRL_W-1:0] ctrl_qb;
  logic [P_W-1:0]    prod;
  logic [ACC_W-1:0]  acc_q;
  logic              ovf_q;
  logic [ACC_W:0]    out_d, out_q;

  assign a_sel  = use_chain ? chain_a_in : a_in;
  assign b_sel  = use_chain ? chain_b_in : b_in;
  assign ctrl_d = '{is_signed: is_signed, sub: sub, load: load};

  mac_stage #(.W(A_W), .EN(IN_A_REG)) u_in_a (
    .clk(clk), .rst(rst), .ce(ce), .d(a_sel), .q(a_q)
  );
  mac_stage #(.W(B_W), .EN(IN_B_REG)) u_in_b (
    .clk(clk), .rst(rst), .ce(ce), .d(b_sel), .q(b_q)
  );
  mac_stage #(.W(CTRL_W), .EN(CTRL_REG)) u_in_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .d(ctrl_d), .q(ctrl_qb)
  );
  assign ctrl_q = mac_ctrl_t'(ctrl_qb);

  assign chain_a_out = a_q;
  assign chain_b_out = b_q;

  mac_mult #(.A_W(A_W), .B_W(B_W), .PIPE(PIPE_REG)) u_mult (
    .clk(clk), .rst(rst), .ce(ce), .a(a_q), .b(b_q),
    .ctrl_in(ctrl_q), .prod(prod), .ctrl_out(ctrl_m)
  );

  mac_accum #(.P_W(P_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .ce(ce), .prod(prod), .ctrl(ctrl_m),
    .acc_q(acc_q), .ovf_q(ovf_q)
  );

  assign out_d = {ovf_q, acc_q};

  mac_stage #(.W(ACC_W + 1), .EN(OUT_REG)) u_out (
    .clk(clk), .rst(rst), .ce(ce), .d(out_d), .q(out_q)
  );

  assign acc_out = out_q[ACC_W-1:0];
  assign ovf_out = out_q[ACC_W];

  // R11: outputs read zero after a reset edge
  a_r11_out_reset: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !ovf_out));
  // R10: outputs frozen while stalled
  a_r10_out_freeze: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(acc_out) && $stable(ovf_out)));
endmodule

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b1;
  logic [7:0] a = '0, b = '0, ca = '0, cb = '0;
  logic       uch = 1'b0, sg = 1'b0, sb = 1'b0, ld = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  logic [7:0]  c0a, c0b, c1a, c1b;
  logic [31:0] acc0;
  logic        ovf0;
  logic [17:0] acc1;
  logic        ovf1;

  mac_unit u0 (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a), .b_in(b),
    .chain_a_in(ca), .chain_b_in(cb), .use_chain(uch),
    .is_signed(sg), .sub(sb), .load(ld),
    .chain_a_out(c0a), .chain_b_out(c0b), .acc_out(acc0), .ovf_out(ovf0)
  );

  mac_unit #(.GUARD(2)) u1 (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a), .b_in(b),
    .chain_a_in(ca), .chain_b_in(cb), .use_chain(uch),
    .is_signed(sg), .sub(sb), .load(ld),
    .chain_a_out(c1a), .chain_b_out(c1b), .acc_out(acc1), .ovf_out(ovf1)
  );

  logic [31:0] lat_acc [16];
  logic        lat_ovf [16];
  logic [7:0]  lat_ca  [16];
  logic [7:0]  lat_cb  [16];

  for (genvar g = 0; g < 16; g++) begin : g_lat
    mac_unit #(
      .IN_A_REG(g % 2), .IN_B_REG((g / 2) % 2),
      .PIPE_REG((g / 4) % 2), .OUT_REG((g / 8) % 2)
    ) u_lat (
      .clk(clk), .rst(rst), .ce(ce), .a_in(a), .b_in(b),
      .chain_a_in(ca), .chain_b_in(cb), .use_chain(uch),
      .is_signed(sg), .sub(sb), .load(ld),
      .chain_a_out(lat_ca[g]), .chain_b_out(lat_cb[g]),
      .acc_out(lat_acc[g]), .ovf_out(lat_ovf[g])
    );
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] ia, input logic [7:0] ib,
                      input logic isg, input logic isb, input logic ild);
    a = ia; b = ib; sg = isg; sb = isb; ld = ild;
    @(negedge clk);
  endtask

  task automatic flush();
    repeat (6) step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1; ce = 1'b1; uch = 1'b0;
    step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(acc0 == 32'd0, "R11", "acc after reset", acc0, 0);
    check(ovf0 == 1'b0, "R11", "ovf after reset", ovf0, 0);
    check(acc1 == 18'd0, "R11", "small acc after reset", acc1, 0);
  endtask

  task automatic t_latency();
    int first [16];
    do_reset();
    flush();
    for (int i = 0; i < 16; i++) first[i] = 0;
    a = 8'd3; b = 8'd5;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); #1;
      for (int i = 0; i < 16; i++)
        if (first[i] == 0 && lat_acc[i] != 32'd0) first[i] = k;
    end
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      int exp_l;
      exp_l = (((i % 2) | ((i / 2) % 2)) != 0 ? 1 : 0) + ((i / 4) % 2) + 1 + ((i / 8) % 2);
      check(first[i] == exp_l, "R8", $sformatf("latency combo %0d", i), first[i], exp_l);
    end
  endtask

  task automatic t_unsigned();
    do_reset();
    step(8'd200, 8'd250, 1'b0, 1'b0, 1'b1);
    step(8'd255, 8'd255, 1'b0, 1'b0, 1'b0);
    step(8'd17,  8'd3,   1'b0, 1'b0, 1'b0);
    flush();
    check(acc0 == 32'd115076, "R1", "unsigned sum", acc0, 115076);
    check(ovf0 == 1'b0, "R1", "no overflow", ovf0, 0);
  endtask

  task automatic t_signed();
    step(8'h80, 8'h7F, 1'b1, 1'b0, 1'b1);
    step(8'hFB, 8'hF9, 1'b1, 1'b0, 1'b0);
    flush();
    check(acc0 == 32'(-16221), "R2", "signed sum", acc0, 32'(-16221));
    check(ovf0 == 1'b0, "R4", "load cleared flag", ovf0, 0);
  endtask

  task automatic t_subtract();
    step(8'd10, 8'd10, 1'b1, 1'b0, 1'b1);
    step(8'd3,  8'd4,  1'b1, 1'b1, 1'b0);
    step(8'd20, 8'd20, 1'b1, 1'b1, 1'b0);
    flush();
    check(acc0 == 32'(-312), "R3", "add then subtract", acc0, 32'(-312));
    step(8'd6, 8'd7, 1'b1, 1'b1, 1'b1);
    flush();
    check(acc0 == 32'(-42), "R4", "load with subtract negates", acc0, 32'(-42));
  endtask

  task automatic t_chain();
    uch = 1'b1; ca = 8'd9; cb = 8'd11;
    step(8'd1, 8'd1, 1'b0, 1'b0, 1'b1);
    check(c0a == 8'd9, "R9", "chain_a_out", c0a, 9);
    check(c0b == 8'd11, "R9", "chain_b_out", c0b, 11);
    uch = 1'b0; ca = 8'd0; cb = 8'd0;
    flush();
    check(acc0 == 32'd99, "R9", "product from chain inputs", acc0, 99);
  endtask

  task automatic t_stall();
    step(8'd3, 8'd4, 1'b0, 1'b0, 1'b1);
    flush();
    ce = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(8'd50, 8'd50, 1'b0, 1'b0, 1'b1);
      check(acc0 == 32'd12, "R10", "held during stall", acc0, 12);
    end
    ce = 1'b1;
    flush();
    check(acc0 == 32'd12, "R10", "stalled inputs ignored", acc0, 12);
  endtask

  task automatic t_mid_reset();
    step(8'd9, 8'd9, 1'b0, 1'b0, 1'b1);
    flush();
    rst = 1'b1;
    step(8'd7, 8'd7, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    check(acc0 == 32'd0, "R11", "acc cleared by reset", acc0, 0);
    check(ovf0 == 1'b0, "R11", "ovf cleared by reset", ovf0, 0);
  endtask

  task automatic t_signed_ovf();
    do_reset();
    step(8'h80, 8'h80, 1'b1, 1'b0, 1'b1);
    repeat (6) step(8'h80, 8'h80, 1'b1, 1'b0, 1'b0);
    flush();
    check(acc1 == 18'd114688, "R5", "signed sum in range", acc1, 114688);
    check(ovf1 == 1'b0, "R5", "no signed overflow yet", ovf1, 0);
    step(8'h80, 8'h80, 1'b1, 1'b0, 1'b0);
    flush();
    check(ovf1 == 1'b1, "R5", "signed overflow", ovf1, 1);
    step(8'h80, 8'h7F, 1'b1, 1'b0, 1'b0);
    flush();
    check(ovf1 == 1'b1, "R7", "flag stays set", ovf1, 1);
    step(8'd1, 8'd1, 1'b0, 1'b0, 1'b1);
    flush();
    check(ovf1 == 1'b0, "R7", "load clears flag", ovf1, 0);
    check(acc1 == 18'd1, "R4", "load value", acc1, 1);
  endtask

  task automatic t_unsigned_ovf();
    step(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1);
    repeat (3) step(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
    flush();
    check(ovf1 == 1'b0, "R6", "no carry yet", ovf1, 0);
    check(acc1 == 18'd260100, "R6", "sum below limit", acc1, 260100);
    step(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
    flush();
    check(ovf1 == 1'b1, "R6", "carry out sets flag", ovf1, 1);
    check(acc1 == 18'd62981, "R6", "wrapped sum", acc1, 62981);
    step(8'd1, 8'd1, 1'b0, 1'b0, 1'b1);
    step(8'd2, 8'd1, 1'b0, 1'b1, 1'b0);
    flush();
    check(ovf1 == 1'b1, "R6", "borrow sets flag", ovf1, 1);
    check(acc1 == 18'h3FFFF, "R6", "borrow result", acc1, 18'h3FFFF);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    a = '0; b = '0;
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_unsigned();
    t_signed();
    t_subtract();
    t_chain();
    t_stall();
    t_mid_reset();
    t_signed_ovf();
    t_unsigned_ovf();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule